// File: doc/BRIEF.md
# DMA Bus-Master Handshake Controller

This block lets a device borrow a shared memory bus to move a run of words. A start pulse with a non-zero word count makes it pull its request line low and wait for the arbiter's grant. The grant input is looked at only on the rising edge of an internal half-rate clock, which toggles every memory clock cycle. Once the grant is seen there, the block acknowledges, releases its request, enables its address drivers and then issues one read or write strobe per word. After the final word it hands the bus back.

A burst output tells the arbiter that more than one word will move under this one grant. Two sticky flags watch the arbiter. The first is set when the grant arrives later than a deadline chosen by a mode input. The second is set when the grant is left asserted for too long while the block is idle. All bus handshake lines are active low, and the block runs on a single memory clock with a synchronous reset.

Top module: `dma_bus_master`

## Requirements
- R1: While reset is high, and on the first cycle after it, bus_req_n, bus_ack_n, drv_en_n, rd_n and wr_n are 1, and burst, late_grant and hold_err are 0.
- R2: A start pulse seen in idle with word_count non-zero drives bus_req_n to 0 on the next cycle. A start pulse with word_count equal to 0 leaves bus_req_n and bus_ack_n at 1.
- R3: The half-rate edge falls on the 2nd, 4th, 6th, ... clock edge after reset is released. The grant is recognised only at such an edge, and only while requesting with bus_grant_n at 0. bus_ack_n goes to 0 and bus_req_n returns to 1 in the cycle after recognition, and bus_ack_n stays at 1 before it.
- R4: drv_en_n goes to 0 one cycle after bus_ack_n does. No strobe is low unless drv_en_n is 0, and the first strobe starts one cycle after drv_en_n falls.
- R5: Each word gets a strobe that is low for exactly 2 cycles, with one high cycle after it. The strobe is rd_n when dir_write is 0 and wr_n when dir_write is 1. Word i (counting from 0) presents word_addr = i while its strobe is low.
- R6: bus_ack_n and drv_en_n stay at 0 for the one cycle after the last strobe rises, then both return to 1 and the block is idle.
- R7: burst stays at 0 for a single-word transfer. For two or more words it goes to 1 together with the request, stays at 1 through the earlier words, and drops when the strobe of the final word starts.
- R8: Let k be the number of clock edges from request assertion up to and including the recognising edge. late_grant is set when k exceeds the limit that deadline_mode selects at start: 0 selects 42, 1 selects 22, 2 selects 11 and 3 selects 4. late_grant then stays set until reset.
- R9: If bus_grant_n is sampled at 0 on more than 6 consecutive edges while the block is idle, hold_err is set and stays set until reset. Such a grant never starts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer (sampled in idle) |
| word_count | input | CW | Number of words to move |
| dir_write | input | 1 | 1 = write strobes, 0 = read strobes |
| deadline_mode | input | 2 | Grant latency limit select |
| bus_grant_n | input | 1 | Arbiter grant, active low |
| bus_req_n | output | 1 | Bus request, active low |
| bus_ack_n | output | 1 | Grant acknowledge, active low |
| drv_en_n | output | 1 | Address driver enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| burst | output | 1 | Several words under one grant |
| word_addr | output | AW | Word index of the current access |
| late_grant | output | 1 | Sticky late-grant flag |
| hold_err | output | 1 | Sticky over-long grant flag |

## Verification
The bench builds the block with its default parameters: a 4-bit word count, an 8-bit address, limits of 42, 22, 11 and 4 cycles, and a hold limit of 6. A small word count makes it possible to sweep every burst length from 1 to 4 in both directions. Each of these runs is tried at grant delays that land on both parities of the half-rate edge. The shortest limit of 4 puts the on-time/late boundary within a few cycles. Each of the four limits is also probed on both sides of its boundary, and idle grant holds of 1 to 9 cycles straddle the hold limit.

// File: rtl/dmah_pkg.sv
package dmah_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ACK,
    ST_DRV,
    ST_STB,
    ST_GAP
  } dmah_state_e;

  // Strobe low time in memory clock cycles.
  localparam int STROBE_CYCLES = 2;

  // Grant counts only on a half-rate edge with the grant line low.
  function automatic logic grant_seen(input logic half_edge, input logic grant_n);
    return half_edge & ~grant_n;
  endfunction

  // The block owns the bus from acknowledge to release.
  function automatic logic owns_bus(input dmah_state_e st);
    return (st == ST_ACK) || (st == ST_DRV) || (st == ST_STB) || (st == ST_GAP);
  endfunction

  // Address drivers are enabled after the acknowledge cycle.
  function automatic logic drives_addr(input dmah_state_e st);
    return (st == ST_DRV) || (st == ST_STB) || (st == ST_GAP);
  endfunction

endpackage

// File: rtl/dmah_halfrate.sv
module dmah_halfrate (
  input  logic clk,
  input  logic rst,
  output logic half_edge
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= 1'b0;
    else     ph_q <= ~ph_q;
  end

  // ph_q is high on every second memory clock edge after reset.
  assign half_edge = ph_q;
endmodule

// File: rtl/dmah_latency.sv
module dmah_latency #(
  parameter int LIM0 = 42,
  parameter int LIM1 = 22,
  parameter int LIM2 = 11,
  parameter int LIM3 = 4,
  parameter int LW   = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       requesting,
  input  logic [1:0] mode,
  output logic       late
);
  logic [LW-1:0] wait_q;
  logic [LW-1:0] limit;
  logic          over;

  always_comb begin
    case (mode)
      2'd0:    limit = LW'(LIM0);
      2'd1:    limit = LW'(LIM1);
      2'd2:    limit = LW'(LIM2);
      default: limit = LW'(LIM3);
    endcase
  end

  // wait_q holds the number of request edges already passed without a grant.
  assign over = requesting && (wait_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q <= '0;
      late   <= 1'b0;
    end else begin
      if (!requesting)         wait_q <= '0;
      else if (wait_q != '1)   wait_q <= wait_q + LW'(1);
      if (over)                late <= 1'b1;
    end
  end
endmodule

// File: rtl/dmah_hold_mon.sv
module dmah_hold_mon #(
  parameter int HOLD_MAX = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic grant_n,
  output logic hold_err
);
  localparam int HW = $clog2(HOLD_MAX + 1);

  logic [HW-1:0] held_q;
  logic          stray;

  assign stray = idle && !grant_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q   <= '0;
      hold_err <= 1'b0;
    end else begin
      if (!stray)                        held_q <= '0;
      else if (held_q != HW'(HOLD_MAX))  held_q <= held_q + HW'(1);
      if (stray && held_q == HW'(HOLD_MAX)) hold_err <= 1'b1;
    end
  end
endmodule

// File: rtl/dmah_seq.sv
module dmah_seq
  import dmah_pkg::*;
#(
  parameter int CW = 4,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] word_count,
  input  logic          dir_write,
  input  logic [1:0]    deadline_mode,
  input  logic          grant_ok,
  output dmah_state_e   state,
  output logic          dir_q,
  output logic          multi_q,
  output logic [1:0]    mode_q,
  output logic          last_word,
  output logic [AW-1:0] addr_q
);
  localparam int SBW = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
  localparam logic [SBW-1:0] STB_LAST = SBW'(STROBE_CYCLES - 1);

  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  idx_q;
  logic [SBW-1:0] stb_q;
  logic           launch;

  assign launch    = start && (word_count != '0);
  assign last_word = (idx_q == cnt_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
      stb_q   <= '0;
      dir_q   <= 1'b0;
      multi_q <= 1'b0;
      mode_q  <= 2'd0;
    end else begin
      case (state)
        ST_IDLE: if (launch) begin
          state   <= ST_REQ;
          cnt_q   <= word_count;
          idx_q   <= '0;
          addr_q  <= '0;
          dir_q   <= dir_write;
          multi_q <= (word_count > CW'(1));
          mode_q  <= deadline_mode;
        end
        ST_REQ:  if (grant_ok) state <= ST_ACK;
        ST_ACK:  state <= ST_DRV;
        ST_DRV: begin
          state <= ST_STB;
          stb_q <= '0;
        end
        ST_STB: begin
          if (stb_q == STB_LAST) begin
            state <= ST_GAP;
            stb_q <= '0;
          end else begin
            stb_q <= stb_q + SBW'(1);
          end
        end
        ST_GAP: begin
          if (last_word) begin
            state   <= ST_IDLE;
            multi_q <= 1'b0;
          end else begin
            state  <= ST_STB;
            idx_q  <= idx_q + CW'(1);
            addr_q <= addr_q + AW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_bus_master.sv
module dma_bus_master
  import dmah_pkg::*;
#(
  parameter int CW       = 4,
  parameter int AW       = 8,
  parameter int LIM0     = 42,
  parameter int LIM1     = 22,
  parameter int LIM2     = 11,
  parameter int LIM3     = 4,
  parameter int HOLD_MAX = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] word_count,
  input  logic          dir_write,
  input  logic [1:0]    deadline_mode,
  input  logic          bus_grant_n,
  output logic          bus_req_n,
  output logic          bus_ack_n,
  output logic          drv_en_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          burst,
  output logic [AW-1:0] word_addr,
  output logic          late_grant,
  output logic          hold_err
);
  localparam int LMAX01 = (LIM0 > LIM1) ? LIM0 : LIM1;
  localparam int LMAX23 = (LIM2 > LIM3) ? LIM2 : LIM3;
  localparam int LMAX   = (LMAX01 > LMAX23) ? LMAX01 : LMAX23;
  localparam int LW     = $clog2(LMAX + 2);

  // Named internal events, visible to the bound checker.
  dmah_state_e state;
  logic        half_edge;
  logic        grant_ok;
  logic        in_strobe;
  logic        final_phase;
  logic        dir_q;
  logic        multi_q;
  logic [1:0]  mode_q;
  logic        last_word;

  assign grant_ok = grant_seen(half_edge, bus_grant_n);

  dmah_halfrate u_half (
    .clk       (clk),
    .rst       (rst),
    .half_edge (half_edge)
  );

  dmah_seq #(.CW(CW), .AW(AW)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .word_count    (word_count),
    .dir_write     (dir_write),
    .deadline_mode (deadline_mode),
    .grant_ok      (grant_ok),
    .state         (state),
    .dir_q         (dir_q),
    .multi_q       (multi_q),
    .mode_q        (mode_q),
    .last_word     (last_word),
    .addr_q        (word_addr)
  );

  dmah_latency #(
    .LIM0 (LIM0), .LIM1 (LIM1), .LIM2 (LIM2), .LIM3 (LIM3), .LW (LW)
  ) u_lat (
    .clk        (clk),
    .rst        (rst),
    .requesting (state == ST_REQ),
    .mode       (mode_q),
    .late       (late_grant)
  );

  dmah_hold_mon #(.HOLD_MAX(HOLD_MAX)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .idle     (state == ST_IDLE),
    .grant_n  (bus_grant_n),
    .hold_err (hold_err)
  );

  assign in_strobe   = (state == ST_STB);
  assign final_phase = ((state == ST_STB) || (state == ST_GAP)) && last_word;

  assign bus_req_n = ~(state == ST_REQ);
  assign bus_ack_n = ~owns_bus(state);
  assign drv_en_n  = ~drives_addr(state);
  assign rd_n      = ~(in_strobe && !dir_q);
  assign wr_n      = ~(in_strobe && dir_q);
  assign burst     = multi_q && (state != ST_IDLE) && !final_phase;
endmodule

// File: rtl/dmah_checker.sv
module dmah_checker (
  input logic clk,
  input logic rst,
  input logic bus_grant_n,
  input logic bus_req_n,
  input logic bus_ack_n,
  input logic drv_en_n,
  input logic rd_n,
  input logic wr_n,
  input logic burst,
  input logic late_grant,
  input logic hold_err,
  input logic half_edge
);
  // R3: acknowledge only follows a half-rate edge with the grant low
  assert_ack_on_half_edge_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack_n) |-> ($past(half_edge) && !$past(bus_grant_n)));

  // R3: request and acknowledge are never low together
  assert_req_released_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_ack_n |-> bus_req_n);

  // R4: a strobe only while the address drivers are on
  assert_strobe_needs_drv_R4: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !drv_en_n);

  // R4: drivers come on one cycle after the acknowledge
  assert_drv_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_en_n) |-> ($past(!bus_ack_n) && $past(drv_en_n)));

  // R5: read strobe is two cycles wide
  assert_rd_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |=> !rd_n ##1 rd_n);

  // R5: write strobe is two cycles wide
  assert_wr_width_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |=> !wr_n ##1 wr_n);

  // R5: never both strobes at once
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    rd_n || wr_n);

  // R6: acknowledge is released only with strobes high for a cycle
  assert_ack_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack_n) |-> (rd_n && wr_n && $past(rd_n) && $past(wr_n)));

  // R7: burst only while requesting or owning the bus
  assert_burst_context_R7: assert property (@(posedge clk) disable iff (rst)
    burst |-> (!bus_req_n || !bus_ack_n));

  // R8: late flag is sticky
  assert_late_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    late_grant |=> late_grant);

  // R9: hold error is sticky
  assert_hold_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    hold_err |=> hold_err);
endmodule

bind dma_bus_master dmah_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_grant_n (bus_grant_n),
  .bus_req_n   (bus_req_n),
  .bus_ack_n   (bus_ack_n),
  .drv_en_n    (drv_en_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .burst       (burst),
  .late_grant  (late_grant),
  .hold_err    (hold_err),
  .half_edge   (half_edge)
);

// File: tb/dma_bus_master_test.sv
module dma_bus_master_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] word_count = 4'd0;
  logic       dir_write = 1'b0;
  logic [1:0] deadline_mode = 2'd0;
  logic       bus_grant_n = 1'b1;
  logic       bus_req_n, bus_ack_n, drv_en_n, rd_n, wr_n, burst;
  logic [7:0] word_addr;
  logic       late_grant, hold_err;

  int checks = 0;
  int fails = 0;
  int ecount = 0;
  bit late_exp = 1'b0;

  always #2 clk = ~clk;

  dma_bus_master uut (
    .clk (clk), .rst (rst), .start (start), .word_count (word_count),
    .dir_write (dir_write), .deadline_mode (deadline_mode),
    .bus_grant_n (bus_grant_n), .bus_req_n (bus_req_n), .bus_ack_n (bus_ack_n),
    .drv_en_n (drv_en_n), .rd_n (rd_n), .wr_n (wr_n), .burst (burst),
    .word_addr (word_addr), .late_grant (late_grant), .hold_err (hold_err)
  );

  // Edge number since reset release (edge 1 is the first one).
  always @(posedge clk) begin
    if (rst) ecount <= 0;
    else     ecount <= ecount + 1;
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", what, act, exp, ecount);
    end
  endtask

  function automatic int limit_of(input int mode);
    case (mode)
      0: return 42;
      1: return 22;
      2: return 11;
      default: return 4;
    endcase
  endfunction

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1; start = 1'b0; bus_grant_n = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    late_exp = 1'b0;
  endtask

  // One transfer: n words, direction wr, deadline mode, grant after d cycles,
  // pre idle cycles before the start pulse.
  task automatic xfer(input int n, input int wr, input int mode, input int d,
                      input int pre, input bit do_rst);
    int e0, j, k, last_o;
    if (do_rst) reset_dut();
    repeat (pre) @(negedge clk);
    start = 1'b1; word_count = 4'(n); dir_write = wr[0]; deadline_mode = 2'(mode);
    e0 = ecount + 1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 request after start", int'(bus_req_n), 0);
    chk("R7 burst with request", int'(burst), (n > 1) ? 1 : 0);
    for (int i = 0; i < d; i++) begin
      chk("R3 no ack before grant", int'(bus_ack_n), 1);
      @(negedge clk);
    end
    bus_grant_n = 1'b0;
    j = ecount + 1;
    if ((j % 2) != 0) j++;
    while (ecount < j) begin
      chk("R3 ack waits for half-rate edge", int'(bus_ack_n), 1);
      chk("R3 request held while waiting", int'(bus_req_n), 0);
      @(negedge clk);
    end
    k = j - e0;
    if (k > limit_of(mode)) late_exp = 1'b1;
    last_o = 2 + 3 * n;
    for (int o = 0; o <= last_o; o++) begin
      int r, w, p;
      bit stb;
      r = o - 2; w = (o >= 2) ? r / 3 : 0; p = (o >= 2) ? r % 3 : 0;
      stb = (o >= 2) && (o < last_o) && (p < 2);
      chk("R3 acknowledge window", int'(bus_ack_n), (o < last_o) ? 0 : 1);
      chk("R3 request released", int'(bus_req_n), 1);
      chk("R4 R6 driver enable window", int'(drv_en_n), (o >= 1 && o < last_o) ? 0 : 1);
      chk("R5 read strobe", int'(rd_n), (stb && wr == 0) ? 0 : 1);
      chk("R5 write strobe", int'(wr_n), (stb && wr == 1) ? 0 : 1);
      chk("R7 burst level", int'(burst),
          ((n > 1) && (o < last_o) && (o < 2 || w < n - 1)) ? 1 : 0);
      if (stb) chk("R5 word address", int'(word_addr), w);
      if (o == 0) bus_grant_n = 1'b1;
      if (o < last_o) @(negedge clk);
    end
    chk("R8 late flag", int'(late_grant), int'(late_exp));
    chk("R9 no hold error in normal use", int'(hold_err), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    // R1: reset values, during reset and on the first cycle after
    @(negedge clk);
    chk("R1 req during reset", int'(bus_req_n), 1);
    chk("R1 ack during reset", int'(bus_ack_n), 1);
    reset_dut();
    chk("R1 req", int'(bus_req_n), 1);
    chk("R1 ack", int'(bus_ack_n), 1);
    chk("R1 drv", int'(drv_en_n), 1);
    chk("R1 rd", int'(rd_n), 1);
    chk("R1 wr", int'(wr_n), 1);
    chk("R1 burst", int'(burst), 0);
    chk("R1 late", int'(late_grant), 0);
    chk("R1 hold", int'(hold_err), 0);

    // R2: zero word count is ignored
    @(negedge clk);
    start = 1'b1; word_count = 4'd0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R2 zero count no request", int'(bus_req_n), 1);
      chk("R2 zero count no ack", int'(bus_ack_n), 1);
      @(negedge clk);
    end

    // Sweep lengths, directions, grant delays and half-rate parity (limit 4)
    for (int n = 1; n <= 4; n++)
      for (int wr = 0; wr <= 1; wr++)
        for (int d = 0; d <= 3; d++)
          for (int pre = 0; pre <= 1; pre++)
            xfer(n, wr, 3, d, pre, 1'b1);

    // R8: every deadline probed on both sides of its limit
    for (int mode = 0; mode <= 3; mode++)
      for (int dd = -3; dd <= 1; dd++)
        for (int pre = 0; pre <= 1; pre++)
          xfer(2, pre, mode, limit_of(mode) + dd, pre, 1'b1);

    // R8: sticky across a following on-time transfer
    xfer(1, 0, 3, 6, 0, 1'b1);
    chk("R8 late set", int'(late_grant), 1);
    xfer(3, 1, 0, 0, 1, 1'b0);
    chk("R8 late still set", int'(late_grant), 1);

    // R9: stray grant in idle, 1..9 cycles
    for (int h = 1; h <= 9; h++) begin
      reset_dut();
      bus_grant_n = 1'b0;
      for (int i = 0; i < h; i++) begin
        @(negedge clk);
        chk("R9 stray grant starts nothing", int'(bus_ack_n), 1);
      end
      bus_grant_n = 1'b1;
      @(negedge clk);
      chk("R9 hold error threshold", int'(hold_err), (h > 6) ? 1 : 0);
      chk("R9 no request from stray grant", int'(bus_req_n), 1);
      repeat (2) @(negedge clk);
      chk("R9 hold error sticky", int'(hold_err), (h > 6) ? 1 : 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule